// File: doc/BRIEF.md
# Leap-Second-Aware UTC Time-of-Day and Calendar Counter

This block keeps UTC year, month, day, hour, minute and second, and advances them by one second on each single-cycle pulse of a one-pulse-per-second strobe. A parallel local-time view is formed from the UTC fields by adding a signed whole-hour offset (a parameter). That view carries its own date, so the local day, month and year step back or forward when the offset crosses midnight.

A user can schedule one leap second. A rising edge on the arm input books the event, and the level of the sign input is captured at that moment (0 = insert, 1 = delete). The event is applied only at UTC midnight at the end of the last day of the current month. An insertion shows second 60 after 23:59:59. A deletion goes straight from 23:59:58 to 00:00:00. The pending flag then clears by itself. A load strobe writes all six UTC fields and leaves the pending state as it is.

The leap control is a three-state machine:
- `LC_IDLE` goes to `LC_ARMED` on an arm rising edge (the "book" transition).
- `LC_ARMED` goes to `LC_LEAP60` on the strobe at 23:59:59 of the month's last day when inserting (the "insert" transition).
- `LC_ARMED` goes back to `LC_IDLE` on the strobe at 23:59:58 of that day when deleting (the "delete" transition).
- `LC_LEAP60` goes to `LC_IDLE` on the next strobe, which yields 00:00:00 (the "finish" transition).

Top module: `utc_leap_clock`

## Requirements
- R1: Each cycle with `pps` high and `ld_en` low advances the UTC time by exactly one second. With neither strobe high, every output holds its value.
- R2: With an insertion booked, the strobes at the end of the month's last day yield 23:59:58, 23:59:59, 23:59:60, then 00:00:00 on the first day of the next month.
- R3: With a deletion booked, the strobe at 23:59:58 of the month's last day yields 00:00:00 of the next day, and second 59 never appears.
- R4: At any midnight other than the end of a month's last day, a booked event is ignored: the time rolls normally and `leap_pending` stays 1.
- R5: A rising edge of `arm_in` while nothing is booked sets `leap_pending` one cycle later and captures `sign_in` (0 = insert, 1 = delete). Later changes of `sign_in` do not affect the booked event.
- R6: `leap_pending` clears on the strobe that completes the leap. A level held high on `arm_in` does not book again. Only a new low-to-high transition does.
- R7: Month lengths follow the Gregorian calendar. February has 29 days in years divisible by 4, except century years that are not divisible by 400.
- R8: A cycle with `ld_en` high writes all six load fields into the UTC outputs on the next cycle. It takes priority over `pps` and leaves `leap_pending` unchanged.
- R9: The local fields equal UTC shifted by `LOCAL_OFF_H` hours (default -8), with minutes and seconds unchanged. The date borrows or carries across day, month and year, so an inserted second shows locally as 15:59:60.
- R10: After reset the UTC time is 2000-01-01 00:00:00 and `leap_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps | input | 1 | One-cycle second strobe |
| ld_en | input | 1 | Load strobe for the UTC fields |
| ld_year | input | 12 | Year to load |
| ld_month | input | 4 | Month to load (1-12) |
| ld_day | input | 5 | Day to load (1-31) |
| ld_hour | input | 5 | Hour to load (0-23) |
| ld_min | input | 6 | Minute to load (0-59) |
| ld_sec | input | 6 | Second to load (0-59) |
| arm_in | input | 1 | Leap booking control, acts on its rising edge |
| sign_in | input | 1 | Leap sign: 0 insert, 1 delete |
| utc_year | output | 12 | UTC year |
| utc_month | output | 4 | UTC month |
| utc_day | output | 5 | UTC day |
| utc_hour | output | 5 | UTC hour |
| utc_min | output | 6 | UTC minute |
| utc_sec | output | 6 | UTC second (0-60) |
| loc_year | output | 12 | Local year |
| loc_month | output | 4 | Local month |
| loc_day | output | 5 | Local day |
| loc_hour | output | 5 | Local hour |
| loc_min | output | 6 | Local minute |
| loc_sec | output | 6 | Local second |
| leap_pending | output | 1 | A leap second is booked and not yet completed |

## Verification
The assertions take it for granted that loaded fields form a valid date and time and that a load never lands while second 60 is showing. They also assume `pps` pulses last one cycle and never coincide with an arm edge. The stimulus respects all of this. Random loads always build a legal date from the month length of the chosen year. Before any load, an extra strobe is issued whenever the time sits at second 60. Arm edges and second strobes are driven on separate cycles. Loads cluster in the last seconds of a month's last day, so that booked insertions, deletions and ignored midnights all occur often.

// File: rtl/utc_clk_pkg.sv
package utc_clk_pkg;

    localparam int YEAR_W  = 12;
    localparam int MONTH_W = 4;
    localparam int DAY_W   = 5;
    localparam int HOUR_W  = 5;
    localparam int MIN_W   = 6;
    localparam int SEC_W   = 6;

    typedef enum logic [1:0] {
        LC_IDLE,
        LC_ARMED,
        LC_LEAP60
    } lc_state_t;

    function automatic logic leap_year(input logic [YEAR_W-1:0] y);
        int yi;
        yi = int'(y);
        return (((yi % 4) == 0) && ((yi % 100) != 0)) || ((yi % 400) == 0);
    endfunction

    function automatic logic [DAY_W-1:0] month_days(input logic [YEAR_W-1:0] y,
                                                    input logic [MONTH_W-1:0] m);
        logic [DAY_W-1:0] d;
        case (m)
            4'd2:                      d = leap_year(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
            default:                   d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/leap_ctrl.sv
module leap_ctrl
    import utc_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps,
    input  logic              ld_en,
    input  logic              arm_in,
    input  logic              sign_in,
    input  logic              last_day,
    input  logic [HOUR_W-1:0] hour,
    input  logic [MIN_W-1:0]  minute,
    input  logic [SEC_W-1:0]  second,
    output logic              pending,
    output logic              ins_req,
    output logic              del_req
);

    lc_state_t state_q, state_d;
    logic      arm_q;
    logic      sign_q;
    logic      arm_rise;
    logic      tick;
    logic      ins_point;
    logic      del_point;

    assign arm_rise  = arm_in & ~arm_q;
    assign tick      = pps & ~ld_en;
    assign ins_point = last_day && (hour == 5'd23) && (minute == 6'd59) && (second == 6'd59);
    assign del_point = last_day && (hour == 5'd23) && (minute == 6'd59) && (second == 6'd58);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LC_IDLE:   if (arm_rise) state_d = LC_ARMED;
            LC_ARMED: begin
                if (tick && ins_point && !sign_q)     state_d = LC_LEAP60;
                else if (tick && del_point && sign_q) state_d = LC_IDLE;
            end
            LC_LEAP60: if (tick) state_d = LC_IDLE;
            default:   state_d = LC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LC_IDLE;
            arm_q   <= 1'b0;
            sign_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            arm_q   <= arm_in;
            if (state_q == LC_IDLE && arm_rise) sign_q <= sign_in;
        end
    end

    // outputs
    always_comb begin
        pending = (state_q != LC_IDLE);
        ins_req = (state_q == LC_ARMED) && !sign_q && ins_point && tick;
        del_req = (state_q == LC_ARMED) &&  sign_q && del_point && tick;
    end

    AST_BOOK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LC_IDLE && arm_rise) |=> pending) else $error("book");       // R5
    AST_SIGN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && $past(pending)) |-> $stable(sign_q)) else $error("sign");     // R5
    AST_CLEAR_AFTER_60: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LC_LEAP60 && tick) |=> !pending) else $error("clear");        // R6
    AST_DEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        del_req |=> !pending) else $error("delclear");                            // R6

endmodule

// File: rtl/utc_calendar.sv
module utc_calendar
    import utc_clk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pps,
    input  logic               ld_en,
    input  logic [YEAR_W-1:0]  ld_year,
    input  logic [MONTH_W-1:0] ld_month,
    input  logic [DAY_W-1:0]   ld_day,
    input  logic [HOUR_W-1:0]  ld_hour,
    input  logic [MIN_W-1:0]   ld_min,
    input  logic [SEC_W-1:0]   ld_sec,
    input  logic               ins_req,
    input  logic               del_req,
    output logic [YEAR_W-1:0]  year,
    output logic [MONTH_W-1:0] month,
    output logic [DAY_W-1:0]   day,
    output logic [HOUR_W-1:0]  hour,
    output logic [MIN_W-1:0]   minute,
    output logic [SEC_W-1:0]   second,
    output logic               last_day
);

    localparam logic [YEAR_W-1:0] YR_ONE   = YEAR_W'(1);
    localparam logic [YEAR_W-1:0] YR_RESET = YEAR_W'(2000);

    assign last_day = (day == month_days(year, month));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            year   <= YR_RESET;
            month  <= 4'd1;
            day    <= 5'd1;
            hour   <= 5'd0;
            minute <= 6'd0;
            second <= 6'd0;
        end else if (ld_en) begin
            year   <= ld_year;
            month  <= ld_month;
            day    <= ld_day;
            hour   <= ld_hour;
            minute <= ld_min;
            second <= ld_sec;
        end else if (pps) begin
            if (ins_req) begin
                second <= 6'd60;
            end else if (second >= 6'd59 || del_req) begin
                second <= 6'd0;
                if (minute == 6'd59) begin
                    minute <= 6'd0;
                    if (hour == 5'd23) begin
                        hour <= 5'd0;
                        if (last_day) begin
                            day <= 5'd1;
                            if (month == 4'd12) begin
                                month <= 4'd1;
                                year  <= year + YR_ONE;
                            end else begin
                                month <= month + 4'd1;
                            end
                        end else begin
                            day <= day + 5'd1;
                        end
                    end else begin
                        hour <= hour + 5'd1;
                    end
                end else begin
                    minute <= minute + 6'd1;
                end
            end else begin
                second <= second + 6'd1;
            end
        end
    end

    AST_NO_PPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pps && !ld_en) |=> ($stable(second) && $stable(minute) && $stable(hour)
                              && $stable(day) && $stable(month) && $stable(year))) else $error("hold"); // R1
    AST_SIXTY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (second == 6'd60) |-> (hour == 5'd23 && minute == 6'd59 && last_day)) else $error("sixty"); // R2
    AST_SIXTY_ROLLS: assert property (@(posedge clk) disable iff (!rst_n)
        (pps && !ld_en && second == 6'd60) |=> (second == 6'd0 && hour == 5'd0 && day == 5'd1)) else $error("roll"); // R2
    AST_DEL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pps && !ld_en && del_req) |=> (second == 6'd0 && minute == 6'd0 && hour == 5'd0)) else $error("del"); // R3
    AST_DAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (day >= 5'd1 && day <= month_days(year, month))) else $error("day");    // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (second == $past(ld_sec) && day == $past(ld_day))) else $error("load"); // R8

endmodule

// File: rtl/loc_view.sv
module loc_view
    import utc_clk_pkg::*;
#(
    parameter int OFF_H = -8
) (
    input  logic [YEAR_W-1:0]  year,
    input  logic [MONTH_W-1:0] month,
    input  logic [DAY_W-1:0]   day,
    input  logic [HOUR_W-1:0]  hour,
    input  logic [MIN_W-1:0]   minute,
    input  logic [SEC_W-1:0]   second,
    output logic [YEAR_W-1:0]  l_year,
    output logic [MONTH_W-1:0] l_month,
    output logic [DAY_W-1:0]   l_day,
    output logic [HOUR_W-1:0]  l_hour,
    output logic [MIN_W-1:0]   l_min,
    output logic [SEC_W-1:0]   l_sec
);

    localparam logic [YEAR_W-1:0] YR_ONE = YEAR_W'(1);

    int hsum;

    always_comb begin
        hsum    = int'(hour) + OFF_H;
        l_year  = year;
        l_month = month;
        l_day   = day;
        l_min   = minute;
        l_sec   = second;
        if (hsum < 0) begin
            l_hour = HOUR_W'(hsum + 24);
            if (day == 5'd1) begin
                if (month == 4'd1) begin
                    l_year  = year - YR_ONE;
                    l_month = 4'd12;
                    l_day   = 5'd31;
                end else begin
                    l_month = month - 4'd1;
                    l_day   = month_days(year, month - 4'd1);
                end
            end else begin
                l_day = day - 5'd1;
            end
        end else if (hsum > 23) begin
            l_hour = HOUR_W'(hsum - 24);
            if (day == month_days(year, month)) begin
                l_day = 5'd1;
                if (month == 4'd12) begin
                    l_month = 4'd1;
                    l_year  = year + YR_ONE;
                end else begin
                    l_month = month + 4'd1;
                end
            end else begin
                l_day = day + 5'd1;
            end
        end else begin
            l_hour = HOUR_W'(hsum);
        end
    end

endmodule

// File: rtl/utc_leap_clock.sv
module utc_leap_clock
    import utc_clk_pkg::*;
#(
    parameter int LOCAL_OFF_H = -8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pps,
    input  logic               ld_en,
    input  logic [YEAR_W-1:0]  ld_year,
    input  logic [MONTH_W-1:0] ld_month,
    input  logic [DAY_W-1:0]   ld_day,
    input  logic [HOUR_W-1:0]  ld_hour,
    input  logic [MIN_W-1:0]   ld_min,
    input  logic [SEC_W-1:0]   ld_sec,
    input  logic               arm_in,
    input  logic               sign_in,
    output logic [YEAR_W-1:0]  utc_year,
    output logic [MONTH_W-1:0] utc_month,
    output logic [DAY_W-1:0]   utc_day,
    output logic [HOUR_W-1:0]  utc_hour,
    output logic [MIN_W-1:0]   utc_min,
    output logic [SEC_W-1:0]   utc_sec,
    output logic [YEAR_W-1:0]  loc_year,
    output logic [MONTH_W-1:0] loc_month,
    output logic [DAY_W-1:0]   loc_day,
    output logic [HOUR_W-1:0]  loc_hour,
    output logic [MIN_W-1:0]   loc_min,
    output logic [SEC_W-1:0]   loc_sec,
    output logic               leap_pending
);

    logic last_day;
    logic ins_req;
    logic del_req;

    leap_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pps      (pps),
        .ld_en    (ld_en),
        .arm_in   (arm_in),
        .sign_in  (sign_in),
        .last_day (last_day),
        .hour     (utc_hour),
        .minute   (utc_min),
        .second   (utc_sec),
        .pending  (leap_pending),
        .ins_req  (ins_req),
        .del_req  (del_req)
    );

    utc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .pps      (pps),
        .ld_en    (ld_en),
        .ld_year  (ld_year),
        .ld_month (ld_month),
        .ld_day   (ld_day),
        .ld_hour  (ld_hour),
        .ld_min   (ld_min),
        .ld_sec   (ld_sec),
        .ins_req  (ins_req),
        .del_req  (del_req),
        .year     (utc_year),
        .month    (utc_month),
        .day      (utc_day),
        .hour     (utc_hour),
        .minute   (utc_min),
        .second   (utc_sec),
        .last_day (last_day)
    );

    loc_view #(.OFF_H(LOCAL_OFF_H)) u_loc (
        .year    (utc_year),
        .month   (utc_month),
        .day     (utc_day),
        .hour    (utc_hour),
        .minute  (utc_min),
        .second  (utc_sec),
        .l_year  (loc_year),
        .l_month (loc_month),
        .l_day   (loc_day),
        .l_hour  (loc_hour),
        .l_min   (loc_min),
        .l_sec   (loc_sec)
    );

    AST_LOCAL_SECONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_sec == utc_sec && loc_min == utc_min)) else $error("local");         // R9
    AST_PENDING_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !pps && !arm_in) |=> $stable(leap_pending)) else $error("ldpend"); // R8

endmodule

// File: tb/utc_leap_clock_tb.sv
module utc_leap_clock_tb;

    localparam int B_OFF = -8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps = 1'b0;
    logic        ld_en = 1'b0;
    logic [11:0] ld_year = '0;
    logic [3:0]  ld_month = '0;
    logic [4:0]  ld_day = '0;
    logic [4:0]  ld_hour = '0;
    logic [5:0]  ld_min = '0;
    logic [5:0]  ld_sec = '0;
    logic        arm_in = 1'b0;
    logic        sign_in = 1'b0;
    logic [11:0] utc_year, loc_year;
    logic [3:0]  utc_month, loc_month;
    logic [4:0]  utc_day, loc_day, utc_hour, loc_hour;
    logic [5:0]  utc_min, loc_min, utc_sec, loc_sec;
    logic        leap_pending;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    int e_y, e_mo, e_d, e_h, e_mi, e_s;
    bit e_pend, e_sgn, arm_lvl;
    int x_y, x_mo, x_d, x_h;

    always #10 clk = ~clk;

    utc_leap_clock u_dut (
        .clk(clk), .rst_n(rst_n), .pps(pps), .ld_en(ld_en),
        .ld_year(ld_year), .ld_month(ld_month), .ld_day(ld_day),
        .ld_hour(ld_hour), .ld_min(ld_min), .ld_sec(ld_sec),
        .arm_in(arm_in), .sign_in(sign_in),
        .utc_year(utc_year), .utc_month(utc_month), .utc_day(utc_day),
        .utc_hour(utc_hour), .utc_min(utc_min), .utc_sec(utc_sec),
        .loc_year(loc_year), .loc_month(loc_month), .loc_day(loc_day),
        .loc_hour(loc_hour), .loc_min(loc_min), .loc_sec(loc_sec),
        .leap_pending(leap_pending)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic int b_dim(int y, int m);
        bit lp;
        lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic m_next_day();
        if (e_d == b_dim(e_y, e_mo)) begin
            e_d = 1;
            if (e_mo == 12) begin e_mo = 1; e_y = e_y + 1; end
            else e_mo = e_mo + 1;
        end else e_d = e_d + 1;
    endtask

    task automatic m_tick();
        bit ld;
        ld = (e_d == b_dim(e_y, e_mo)) && e_h == 23 && e_mi == 59;
        if (e_pend && !e_sgn && ld && e_s == 59) e_s = 60;
        else if (e_s == 60) begin
            e_s = 0; e_mi = 0; e_h = 0; m_next_day(); e_pend = 0;
        end else if (e_pend && e_sgn && ld && e_s == 58) begin
            e_s = 0; e_mi = 0; e_h = 0; m_next_day(); e_pend = 0;
        end else begin
            e_s = e_s + 1;
            if (e_s == 60) begin
                e_s = 0; e_mi = e_mi + 1;
                if (e_mi == 60) begin
                    e_mi = 0; e_h = e_h + 1;
                    if (e_h == 24) begin e_h = 0; m_next_day(); end
                end
            end
        end
    endtask

    task automatic m_local();
        int h;
        h = e_h + B_OFF;
        x_y = e_y; x_mo = e_mo; x_d = e_d;
        if (h < 0) begin
            x_h = h + 24;
            if (e_d > 1) x_d = e_d - 1;
            else if (e_mo > 1) begin x_mo = e_mo - 1; x_d = b_dim(e_y, x_mo); end
            else begin x_y = e_y - 1; x_mo = 12; x_d = 31; end
        end else if (h > 23) begin
            x_h = h - 24;
            if (e_d < b_dim(e_y, e_mo)) x_d = e_d + 1;
            else if (e_mo < 12) begin x_mo = e_mo + 1; x_d = 1; end
            else begin x_y = e_y + 1; x_mo = 1; x_d = 1; end
        end else x_h = h;
    endtask

    task automatic check_all(string tag);
        m_local();
        checks = checks + 1;
        if (int'(utc_year) != e_y || int'(utc_month) != e_mo || int'(utc_day) != e_d ||
            int'(utc_hour) != e_h || int'(utc_min) != e_mi || int'(utc_sec) != e_s ||
            leap_pending != e_pend ||
            int'(loc_year) != x_y || int'(loc_month) != x_mo || int'(loc_day) != x_d ||
            int'(loc_hour) != x_h || int'(loc_min) != e_mi || int'(loc_sec) != e_s) begin
            fails = fails + 1;
            $display("FAIL %s: utc %0d-%0d-%0d %0d:%0d:%0d pend %0d loc %0d-%0d-%0d %0d | exp %0d-%0d-%0d %0d:%0d:%0d pend %0d loc %0d-%0d-%0d %0d",
                tag, utc_year, utc_month, utc_day, utc_hour, utc_min, utc_sec, leap_pending,
                loc_year, loc_month, loc_day, loc_hour,
                e_y, e_mo, e_d, e_h, e_mi, e_s, e_pend, x_y, x_mo, x_d, x_h);
        end
    endtask

    task automatic tick(string tag);
        @(negedge clk) pps = 1'b1;
        @(negedge clk) pps = 1'b0;
        m_tick();
        check_all(tag);
    endtask

    task automatic load(int y, int mo, int d, int h, int mi, int s);
        @(negedge clk);
        ld_year = 12'(y); ld_month = 4'(mo); ld_day = 5'(d);
        ld_hour = 5'(h); ld_min = 6'(mi); ld_sec = 6'(s); ld_en = 1'b1;
        @(negedge clk) ld_en = 1'b0;
        e_y = y; e_mo = mo; e_d = d; e_h = h; e_mi = mi; e_s = s;
    endtask

    task automatic set_arm(bit v);
        @(negedge clk) arm_in = v;
        if (v && !arm_lvl && !e_pend) begin e_pend = 1; e_sgn = sign_in; end
        arm_lvl = v;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2015));
        e_y = 2000; e_mo = 1; e_d = 1; e_h = 0; e_mi = 0; e_s = 0;
        e_pend = 0; e_sgn = 0; arm_lvl = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10 reset state");

        // R1: no strobe, no change; then single steps
        repeat (5) @(negedge clk);
        check_all("R1 idle hold");
        tick("R1 one second");
        tick("R1 second step");

        // R2 / R9: insertion at end of June
        load(2015, 6, 30, 23, 59, 57);
        sign_in = 1'b0;
        set_arm(1'b1);
        check_all("R5 armed insert");
        tick("R2 23:59:58");
        tick("R2 23:59:59");
        tick("R2 R9 23:59:60 local 15:59:60");
        tick("R2 R6 rollover to July 1 and clear");
        // R6: arm still high, no re-booking
        load(2015, 7, 31, 23, 59, 59);
        tick("R6 held arm does not rebook");
        set_arm(1'b0);
        sign_in = 1'b1;
        set_arm(1'b1);
        check_all("R6 toggle rebooks");

        // R5 / R3: sign change after booking has no effect; deletion
        sign_in = 1'b0;
        load(2016, 12, 31, 23, 59, 57);
        check_all("R8 load keeps pending");
        tick("R3 23:59:58");
        tick("R3 R5 skip 59 to new year");
        tick("R3 after deletion");

        // R4: booked insertion ignored at a mid-month midnight
        set_arm(1'b0);
        set_arm(1'b1);
        load(2017, 3, 15, 23, 59, 58);
        tick("R4 mid-month 59");
        tick("R4 mid-month midnight normal");
        load(2017, 3, 31, 23, 59, 59);
        tick("R4 R2 month end 60");
        tick("R2 after 60");

        // R7: February and leap-year rules
        load(2000, 2, 28, 23, 59, 59); tick("R7 2000 is leap");
        load(2100, 2, 28, 23, 59, 59); tick("R7 2100 not leap");
        load(2023, 2, 28, 23, 59, 59); tick("R7 2023 not leap");
        load(2024, 2, 29, 23, 59, 59); tick("R7 2024 feb 29 ends");
        load(2099, 12, 31, 23, 59, 59); tick("R7 year carry");

        // R8: load wins over a simultaneous strobe
        @(negedge clk);
        ld_year = 12'd2030; ld_month = 4'd5; ld_day = 5'd6;
        ld_hour = 5'd7; ld_min = 6'd8; ld_sec = 6'd9; ld_en = 1'b1; pps = 1'b1;
        @(negedge clk) begin ld_en = 1'b0; pps = 1'b0; end
        e_y = 2030; e_mo = 5; e_d = 6; e_h = 7; e_mi = 8; e_s = 9;
        check_all("R8 load beats pps");

        // R9: negative offset crosses into previous month/year
        load(2031, 1, 1, 3, 0, 0);
        check_all("R9 local previous year");

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int y, mo, d, h, mi, s, n;
            if (e_s == 60) tick("R2 random leave 60");
            y  = 2000 + int'($urandom % 400);
            mo = 1 + int'($urandom % 12);
            d  = ($urandom % 3 == 0) ? 1 + int'($urandom % b_dim(y, mo)) : b_dim(y, mo);
            h  = ($urandom % 4 == 0) ? int'($urandom % 24) : 23;
            mi = ($urandom % 4 == 0) ? int'($urandom % 60) : 59;
            s  = 55 + int'($urandom % 5);
            load(y, mo, d, h, mi, s);
            if ($urandom % 2 == 0) begin
                sign_in = 1'($urandom % 2);
                set_arm(1'b0);
                set_arm(1'b1);
                sign_in = 1'($urandom % 2);
            end
            n = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) begin
                repeat (int'($urandom % 3)) @(negedge clk);
                tick("R1 R2 R3 R4 R7 R9 random");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule